// File: doc/BRIEF.md
# Buck Controller Fault Sequencer

This block supervises one channel of a synchronous buck power stage. Its inputs are comparator flags that are already digital and synchronous to the block clock, a tick for each switching cycle, and a pulse that marks the end of a soft-start ramp. From these it decides whether the PWM path may switch, whether the upper FET is held off, and whether the lower FET is forced on. It also issues soft-start restart requests and drives a power-good output.

The channel starts from an idle state with both FETs off. When nothing blocks it, the channel asks for a soft-start and switches. It leaves normal operation for one of three reasons. The first is a hard fault, which parks it in idle. The second is a run of overcurrent cycles or a feedback undervoltage, which starts a hiccup sequence: the FETs stay off for a fixed number of soft-start periods and then the channel retries. The third is feedback overvoltage, which holds the lower FET on as a crowbar until the output falls to undervoltage and then begins a hiccup. If overvoltage is already present before switching has begun, the channel stays idle, so it can start into a prebiased output.

Top module: `buck_fault_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `pwm_en`=0, `ls_on`=0, `hs_off`=1, `ss_restart`=0 and `pgood`=0.
- R2: Any hard fault drives `pwm_en`=0 and `ls_on`=0 one cycle later. A hard fault is `en_ok`=0, `por_ok`=0, `ot_flag`=1, `clk_fault`=1 or `phase_bad`=1. A hard fault takes priority over every other flag, including overvoltage. `hs_off` always equals the inverse of `pwm_en`.
- R3: From idle with no hard fault and `ov_flag`=0, the next cycle shows `pwm_en`=1 together with a `ss_restart` pulse that lasts exactly one cycle.
- R4: In idle, `ov_flag`=1 keeps `pwm_en` at 0 for as long as it stays asserted (prebiased start).
- R5: An `ss_done` pulse during soft-start moves the channel to normal run, and `pwm_en` stays 1. Undervoltage is ignored until that point.
- R6: While switching, the 7th consecutive `sw_tick` that sees `oc_flag`=1 turns both FETs off one cycle later and issues a `ss_restart` pulse. A `sw_tick` with `oc_flag`=0 clears the count.
- R7: `uv_flag`=1 in normal run turns both FETs off one cycle later and begins a hiccup.
- R8: In hiccup, the FETs stay off. Each of the first six `ss_done` pulses brings another one-cycle `ss_restart` pulse. The 7th pulse restores `pwm_en`=1 together with a `ss_restart` pulse.
- R9: `ov_flag`=1 while switching or in hiccup gives `pwm_en`=0 and `ls_on`=1 one cycle later. This holds, whatever `ov_flag` does afterwards, until `uv_flag`=1. After that, `ls_on`=0 and a hiccup begins with a `ss_restart` pulse.
- R10: `pgood` is 1 one cycle after any cycle in which `trk_ok` has been seen high at least once since reset and `uv_flag`, `oc_flag` and `ot_flag` are all 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_ok | input | 1 | Input lockout / enable comparator, 1 = enabled |
| por_ok | input | 1 | Power-on reset complete, 1 = supplies ready |
| oc_flag | input | 1 | Cycle overcurrent flag |
| uv_flag | input | 1 | Feedback below undervoltage threshold |
| ov_flag | input | 1 | Feedback above overvoltage threshold |
| trk_ok | input | 1 | Tracking input above its threshold |
| ot_flag | input | 1 | Over-temperature |
| clk_fault | input | 1 | Sync clock missing |
| phase_bad | input | 1 | Invalid phase selection |
| sw_tick | input | 1 | One-cycle pulse per switching cycle |
| ss_done | input | 1 | One-cycle pulse at soft-start completion |
| pwm_en | output | 1 | PWM path may switch the FETs |
| hs_off | output | 1 | Upper FET forced off |
| ls_on | output | 1 | Lower FET forced on (crowbar) |
| ss_restart | output | 1 | One-cycle soft-start restart request |
| pgood | output | 1 | Power-good |

## Verification
On every cycle, the assertions check several properties. A hard fault leaves both FETs off. Overvoltage during switching engages the crowbar, and the crowbar holds until undervoltage. Idle with overvoltage never starts switching. Every rising edge of `pwm_en` comes with a restart pulse. The FET forcing outputs never conflict. Active undervoltage, overcurrent or over-temperature always pulls power-good low. Only the bench scenarios can show the counting behaviour: the overcurrent count of exactly seven ticks and its clearing on a clean tick, the retry after exactly seven soft-start periods, and the sticky tracking qualification of power-good.

// File: rtl/bfs_pkg.sv
// Shared types for the buck fault sequencer.
// Assumes: nothing; pure type definitions.
package bfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,   // both FETs off, waiting for a clean start
        ST_START   = 3'd1,   // soft-start ramp in progress, switching
        ST_RUN     = 3'd2,   // regulated operation
        ST_HICCUP  = 3'd3,   // both FETs off, counting soft-start periods
        ST_CROWBAR = 3'd4    // lower FET held on after overvoltage
    } seq_state_t;
endpackage

// File: rtl/bfs_oc_filter.sv
// Consecutive-overcurrent filter.
// Counts switching ticks that see the overcurrent flag. A clean tick clears
// the count, and the count is held at zero while disabled. trip is
// combinational and fires on the tick that completes LIMIT consecutive cycles.
// Assumes: tick is a single-cycle pulse synchronous to clk.
module bfs_oc_filter #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic oc,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Consecutive overcurrent tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (tick)         cnt_q <= oc ? cnt_q + 1'b1 : '0;
    end

    // Trip on the tick that reaches the limit
    assign trip = enable && tick && oc && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bfs_hiccup_timer.sv
// Hiccup period timer.
// Counts soft-start completion pulses while active. done fires
// (combinationally) on the pulse that ends the PERIODS-th period. The count
// clears whenever the timer is inactive, so each hiccup starts from zero.
// Assumes: ss_done is a single-cycle pulse.
module bfs_hiccup_timer #(
    parameter int PERIODS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ss_done,
    output logic done
);
    localparam int CW = $clog2(PERIODS + 1);
    logic [CW-1:0] cnt_q;

    // Soft-start period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt_q <= '0;
        else if (ss_done)      cnt_q <= cnt_q + 1'b1;
    end

    // Last period complete
    assign done = active && ss_done && (cnt_q == CW'(PERIODS - 1));
endmodule

// File: rtl/bfs_pgood.sv
// Power-good generator.
// Power-good stays low until the tracking flag has been seen once since
// reset. After that it follows the absence of undervoltage, overcurrent and
// over-temperature, with one register of latency.
// Assumes: flags synchronous to clk.
module bfs_pgood (
    input  logic clk,
    input  logic rst_n,
    input  logic trk_ok,
    input  logic uv,
    input  logic oc,
    input  logic ot,
    output logic pgood
);
    logic trk_seen_q;

    // Sticky tracking qualification
    always_ff @(posedge clk) begin
        if (!rst_n) trk_seen_q <= 1'b0;
        else        trk_seen_q <= trk_seen_q | trk_ok;
    end

    // Registered power-good decision
    always_ff @(posedge clk) begin
        if (!rst_n) pgood <= 1'b0;
        else        pgood <= (trk_seen_q | trk_ok) & ~uv & ~oc & ~ot;
    end
endmodule

// File: rtl/buck_fault_seq.sv
// Per-channel fault sequencer for a synchronous buck stage.
// A state machine orders hard faults, overvoltage crowbar, overcurrent and
// undervoltage hiccup, and start-up. The submodules count overcurrent cycles
// and hiccup periods and generate power-good.
// Assumes: all flags synchronous to clk; sw_tick and ss_done are one-cycle
// pulses; the soft-start timer runs on each ss_restart pulse.
module buck_fault_seq #(
    parameter int OC_LIMIT       = 7,
    parameter int HICCUP_PERIODS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_ok,
    input  logic por_ok,
    input  logic oc_flag,
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic trk_ok,
    input  logic ot_flag,
    input  logic clk_fault,
    input  logic phase_bad,
    input  logic sw_tick,
    input  logic ss_done,
    output logic pwm_en,
    output logic hs_off,
    output logic ls_on,
    output logic ss_restart,
    output logic pgood
);
    import bfs_pkg::*;

    seq_state_t state_q, state_d;
    logic hard_fault, switching, oc_trip, hic_done, restart_d;

    assign hard_fault = !en_ok || !por_ok || ot_flag || clk_fault || phase_bad;
    assign switching  = (state_q == ST_START) || (state_q == ST_RUN);

    bfs_oc_filter #(.LIMIT(OC_LIMIT)) u_oc (
        .clk(clk), .rst_n(rst_n), .enable(switching),
        .tick(sw_tick), .oc(oc_flag), .trip(oc_trip)
    );

    bfs_hiccup_timer #(.PERIODS(HICCUP_PERIODS)) u_hic (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_HICCUP),
        .ss_done(ss_done), .done(hic_done)
    );

    bfs_pgood u_pg (
        .clk(clk), .rst_n(rst_n), .trk_ok(trk_ok),
        .uv(uv_flag), .oc(oc_flag), .ot(ot_flag), .pgood(pgood)
    );

    // Next-state selection in fault priority order
    always_comb begin
        state_d = state_q;
        if (hard_fault) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:    if (!ov_flag) state_d = ST_START;
                ST_START,
                ST_RUN: begin
                    if (ov_flag)                              state_d = ST_CROWBAR;
                    else if (oc_trip)                         state_d = ST_HICCUP;
                    else if (state_q == ST_RUN && uv_flag)    state_d = ST_HICCUP;
                    else if (state_q == ST_START && ss_done)  state_d = ST_RUN;
                end
                ST_HICCUP: begin
                    if (ov_flag)       state_d = ST_CROWBAR;
                    else if (hic_done) state_d = ST_START;
                end
                ST_CROWBAR: if (uv_flag) state_d = ST_HICCUP;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Restart request on entry to start or hiccup, and on each hiccup period
    always_comb begin
        restart_d = ((state_d == ST_START)  && (state_q != ST_START))  ||
                    ((state_d == ST_HICCUP) && (state_q != ST_HICCUP)) ||
                    ((state_d == ST_HICCUP) && (state_q == ST_HICCUP) && ss_done);
    end

    // State and restart-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ss_restart <= 1'b0;
        end else begin
            state_q    <= state_d;
            ss_restart <= restart_d;
        end
    end

    // FET control decode
    assign pwm_en = switching;
    assign hs_off = !switching;
    assign ls_on  = (state_q == ST_CROWBAR);
endmodule

// File: rtl/buck_fault_seq_checker.sv
// Property checker for buck_fault_seq, attached through bind.
// Assumes: observes top-level ports only.
module buck_fault_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic en_ok,
    input logic por_ok,
    input logic oc_flag,
    input logic uv_flag,
    input logic ov_flag,
    input logic ot_flag,
    input logic clk_fault,
    input logic phase_bad,
    input logic pwm_en,
    input logic hs_off,
    input logic ls_on,
    input logic ss_restart,
    input logic pgood
);
    logic hard;
    assign hard = !en_ok || !por_ok || ot_flag || clk_fault || phase_bad;

    assert_hard_fault_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (!pwm_en && !ls_on));

    assert_no_fet_conflict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_en && ls_on) && (hs_off == !pwm_en));

    assert_start_has_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> ss_restart);

    assert_prebias_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && !ls_on && ov_flag) |=> !pwm_en);

    assert_ov_crowbar_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && ov_flag && !hard) |=> (ls_on && !pwm_en));

    assert_crowbar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && !uv_flag && !hard) |=> ls_on);

    assert_pgood_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag || oc_flag || ot_flag) |=> !pgood);
endmodule

bind buck_fault_seq buck_fault_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .por_ok(por_ok),
    .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .ot_flag(ot_flag), .clk_fault(clk_fault), .phase_bad(phase_bad),
    .pwm_en(pwm_en), .hs_off(hs_off), .ls_on(ls_on),
    .ss_restart(ss_restart), .pgood(pgood)
);

// File: tb/buck_fault_seq_bench.sv
module buck_fault_seq_bench;
    logic clk = 1'b0;
    logic rst_n, en_ok, por_ok, oc_flag, uv_flag, ov_flag, trk_ok;
    logic ot_flag, clk_fault, phase_bad, sw_tick, ss_done;
    logic pwm_en, hs_off, ls_on, ss_restart, pgood;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    buck_fault_seq u_buck_fault_seq (
        .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .por_ok(por_ok),
        .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .trk_ok(trk_ok), .ot_flag(ot_flag), .clk_fault(clk_fault),
        .phase_bad(phase_bad), .sw_tick(sw_tick), .ss_done(ss_done),
        .pwm_en(pwm_en), .hs_off(hs_off), .ls_on(ls_on),
        .ss_restart(ss_restart), .pgood(pgood)
    );

    // Packed output view {pwm_en, hs_off, ls_on, ss_restart}
    function automatic logic [3:0] outs();
        return {pwm_en, hs_off, ls_on, ss_restart};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: {pwm,hs_off,ls_on,restart} got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic check_pg(input string req, input logic exp);
        checks++;
        if (pgood !== exp) begin
            errors++;
            $display("FAIL %s: pgood got %b expected %b", req, pgood, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        ss_done = 1'b1; step(1); ss_done = 1'b0;
    endtask

    // R3/R5: start from idle and finish soft-start
    task automatic bring_up();
        step(1); check("R3 start", 4'b1001);
        step(1); check("R3 single pulse", 4'b1000);
        pulse_done(); step(1); check("R5 run", 4'b1000);
    endtask

    // R8: run through a full hiccup back to switching
    task automatic ride_hiccup();
        for (int i = 0; i < 6; i++) begin
            pulse_done(); check("R8 period restart", 4'b0101);
            step(1); check("R8 still off", 4'b0100);
        end
        pulse_done(); check("R8 retry", 4'b1001);
        step(1);
        pulse_done(); step(1); check("R8 back to run", 4'b1000);
    endtask

    task automatic t_reset();
        rst_n = 0; en_ok = 1; por_ok = 1; oc_flag = 0; uv_flag = 0; ov_flag = 0;
        trk_ok = 0; ot_flag = 0; clk_fault = 0; phase_bad = 0; sw_tick = 0; ss_done = 0;
        step(3); check("R1 reset", 4'b0100); check_pg("R1 reset pg", 1'b0);
        en_ok = 0; rst_n = 1; step(1); check("R1 after release", 4'b0100);
        step(2); check("R2 lockout idle", 4'b0100);
        en_ok = 1;
        bring_up();
    endtask

    task automatic t_overcurrent();
        oc_flag = 1;
        for (int i = 0; i < 6; i++) begin sw_tick = 1; step(1); sw_tick = 0; step(1); end
        oc_flag = 0; sw_tick = 1; step(1); sw_tick = 0; step(1);
        check("R6 clean tick clears", 4'b1000);
        oc_flag = 1;
        for (int i = 0; i < 6; i++) begin sw_tick = 1; step(1); sw_tick = 0; step(1); end
        check("R6 six ticks no trip", 4'b1000);
        sw_tick = 1; step(1); sw_tick = 0; oc_flag = 0;
        check("R6 seventh tick trips", 4'b0101);
        step(1); check("R6 hiccup off", 4'b0100);
        ride_hiccup();
    endtask

    task automatic t_undervoltage();
        uv_flag = 1; step(1); uv_flag = 0;
        check("R7 uv hiccup", 4'b0101);
        step(1);
        ride_hiccup();
    endtask

    task automatic t_overvoltage();
        ov_flag = 1; step(1); check("R9 crowbar", 4'b0110);
        ov_flag = 0; step(5); check("R9 crowbar holds", 4'b0110);
        uv_flag = 1; step(1); uv_flag = 0;
        check("R9 uv ends crowbar", 4'b0101);
        step(1);
        ride_hiccup();
    endtask

    task automatic t_hard_faults();
        ov_flag = 1; ot_flag = 1; step(1); ov_flag = 0;
        check("R2 ot beats ov", 4'b0100);
        ot_flag = 0; bring_up();
        clk_fault = 1; step(1); check("R2 clk fault", 4'b0100);
        clk_fault = 0; bring_up();
        phase_bad = 1; step(1); check("R2 phase", 4'b0100);
        phase_bad = 0; bring_up();
        por_ok = 0; step(1); check("R2 por", 4'b0100);
        por_ok = 1; bring_up();
    endtask

    task automatic t_prebias();
        en_ok = 0; step(1); check("R2 disable", 4'b0100);
        ov_flag = 1; en_ok = 1; step(4); check("R4 prebias no start", 4'b0100);
        ov_flag = 0; bring_up();
        uv_flag = 1; step(1); uv_flag = 0;
        check("R5 uv after ss done", 4'b0101);
        en_ok = 0; step(1); en_ok = 1;
        step(1); check("R5 restart", 4'b1001);
        uv_flag = 1; step(2); check("R5 uv ignored in soft-start", 4'b1000);
        uv_flag = 0;
    endtask

    task automatic t_pgood();
        step(1); check_pg("R10 no tracking yet", 1'b0);
        trk_ok = 1; step(1); check_pg("R10 tracking", 1'b1);
        trk_ok = 0; step(1); check_pg("R10 sticky", 1'b1);
        oc_flag = 1; step(1); check_pg("R10 oc", 1'b0);
        oc_flag = 0; uv_flag = 1; step(1); check_pg("R10 uv", 1'b0);
        uv_flag = 0; ot_flag = 1; step(1); check_pg("R10 ot", 1'b0);
        ot_flag = 0; step(1); check_pg("R10 release", 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_overcurrent();
                t_undervoltage();
                t_overvoltage();
                t_hard_faults();
                t_prebias();
                t_pgood();
            end
            begin
                step(20000);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule